// File: doc/BRIEF.md
# Daisy-Chain SPI Host Controller

This block is a SPI host for a string of identical single-channel converters connected in series. The MISO of each device feeds the MOSI of the next. One chip-select window carries an extended frame of N_DEV × WORD_BITS clocks with no break between device words. The controller takes one command word per device and sends it so that each word ends up in the intended device. It also collects the word that each device returns and places it in a per-device result slot. Slot 0 is always the device wired closest to the host.

Reading registers takes two frames. First a normal frame delivers the read command to every device. Then a readback frame, requested with `rd_mode_i`, returns one register byte per device. Each register byte sits at the top of a word-sized slot and is followed by filler bytes. The controller keeps only the register byte of each slot and puts it in a separate byte array, so conversion results from earlier frames are left as they were.

The user side has a start / busy / done handshake. The SPI clock is SPI mode 1: it idles low, the host changes MOSI on the rising edge and samples MISO on the falling edge, and every word is sent MSB first. The SCLK rate comes from a half-period divider of the system clock.

Top module: `dchain_spi_host`

## Requirements
- R1: While reset is held (active-low `rst_n`), and afterwards until a start, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `busy_o`=0, `done_o`=0, and `rdata_o` and `reg_o` are all zeros.
- R2: A start accepted at a clock edge drives `cs_n_o` low from that edge for exactly (2·N_DEV·WORD_BITS+1)·(div_i+1) clock cycles. SCLK toggles every div_i+1 cycles, starting one half period after `cs_n_o` falls. This gives exactly N_DEV·WORD_BITS contiguous SCLK periods, followed by one half period before `cs_n_o` rises.
- R3: SCLK is low whenever `cs_n_o` is high. While `cs_n_o` stays constant, `mosi_o` changes only on a rising SCLK edge. MISO is sampled on falling SCLK edges.
- R4: `cmd_i` is a flat vector in which device slot d occupies bits [(d+1)·WORD_BITS-1 : d·WORD_BITS], with d=0 nearest the host. The frame sends slot N_DEV-1 first and slot 0 last, each word MSB first. At the end of the frame, device d holds cmd slot d.
- R5: The first word received on MISO is stored in slot N_DEV-1 of `rdata_o` and the last word in slot 0, so slot d holds the word sent by device d (same bit layout as R4).
- R6: In a readback frame (`rd_mode_i`=1 at start), byte d of `reg_o` (bits [8d+7:8d]) becomes the most significant byte of the word received from device d. The remaining filler bytes of each slot are discarded whatever their value.
- R7: A data frame updates `rdata_o` and leaves `reg_o` unchanged. A readback frame updates `reg_o` and leaves `rdata_o` unchanged. Neither output changes except in the cycle `done_o` is high.
- R8: `done_o` is high for exactly one clock cycle, the cycle in which `cs_n_o` returns high, and the result outputs are already valid in that cycle.
- R9: `busy_o` is high from the accepting edge until 4 SCLK half periods (2 SCLK periods) after `cs_n_o` rises. During this time `cs_n_o` stays high, and no new frame can start before it has elapsed.
- R10: A start pulse while `busy_o` is high is ignored. `cmd_i`, `div_i` and `rd_mode_i` are captured at the accepting edge, and later changes to them have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a frame (accepted only when idle) |
| rd_mode_i | input | 1 | 1: readback frame (register bytes), 0: data frame |
| div_i | input | DIV_W | SCLK half period minus one, in clock cycles |
| cmd_i | input | N_DEV*WORD_BITS | Command words, slot 0 = device nearest host |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| rdata_o | output | N_DEV*WORD_BITS | Words received in the last data frame |
| reg_o | output | N_DEV*8 | Register bytes from the last readback frame |
| sclk_o | output | 1 | SPI clock, idles low |
| cs_n_o | output | 1 | Shared chip select, active low |
| mosi_o | output | 1 | Serial data to the first device |
| miso_i | input | 1 | Serial data from the last device |

## Verification
The assertions assume that the chain presents MISO changes only after rising SCLK edges, and that `rst_n` is synchronous to `clk`. The bench meets this with a behavioural chain model that updates its output on SCLK rising edges and shifts in MOSI on falling edges. Nothing is assumed about `start_i`, `cmd_i`, `div_i` or `rd_mode_i` while busy. The stimulus deliberately pulses start and rewrites these inputs in the middle of a frame, and a per-cycle timing model predicts that they are ignored. Readback frames are driven with both zero and non-zero filler bytes.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } dc_state_e;

   // half periods of SCLK that chip select stays high after a frame
   localparam int unsigned GAP_HALVES = 4;
   // width of a register byte inside a readback slot
   localparam int unsigned REG_BITS   = 8;
endpackage

// File: rtl/dchain_tick.sv
module dchain_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         div_q <= div_i;
         cnt_q <= div_i;
      end else if (run_i) begin
         cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
      end
   end

   assign tick_o = run_i && !load_i && (cnt_q == '0);
endmodule

// File: rtl/dchain_shifter.sv
module dchain_shifter #(
   parameter int unsigned TOT_BITS = 96
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [TOT_BITS-1:0] data_i,
   input  logic                drive_i,
   input  logic                sample_i,
   input  logic                clear_i,
   input  logic                miso_i,
   output logic                mosi_o,
   output logic [TOT_BITS-1:0] rx_o
);
   logic [TOT_BITS-1:0] tx_q;
   logic [TOT_BITS-1:0] rx_q;
   logic                mosi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_q <= 1'b0;
      end else if (load_i) begin
         tx_q   <= data_i;
         rx_q   <= '0;
         mosi_q <= 1'b0;
      end else begin
         if (drive_i) begin
            mosi_q <= tx_q[TOT_BITS-1];
            tx_q   <= {tx_q[TOT_BITS-2:0], 1'b0};
         end else if (clear_i) begin
            mosi_q <= 1'b0;
         end
         if (sample_i) begin
            rx_q <= {rx_q[TOT_BITS-2:0], miso_i};
         end
      end
   end

   assign mosi_o = mosi_q;
   assign rx_o   = rx_q;
endmodule

// File: rtl/dchain_unpack.sv
module dchain_unpack
   import dchain_pkg::*;
#(
   parameter int unsigned N_DEV     = 4,
   parameter int unsigned WORD_BITS = 24
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit_i,
   input  logic                         rd_mode_i,
   input  logic [N_DEV*WORD_BITS-1:0]   rx_i,
   output logic [N_DEV*WORD_BITS-1:0]   rdata_o,
   output logic [N_DEV*REG_BITS-1:0]    reg_o
);
   localparam int unsigned PAD_BITS = WORD_BITS - REG_BITS;

   for (genvar s = 0; s < N_DEV; s++) begin : g_slot
      logic [WORD_BITS-1:0] word_q;
      logic [REG_BITS-1:0]  byte_q;
      logic [WORD_BITS-1:0] word_in;

      assign word_in = rx_i[s*WORD_BITS +: WORD_BITS];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
            byte_q <= '0;
         end else if (commit_i) begin
            if (rd_mode_i) begin
               byte_q <= word_in[PAD_BITS +: REG_BITS];
            end else begin
               word_q <= word_in;
            end
         end
      end

      assign rdata_o[s*WORD_BITS +: WORD_BITS] = word_q;
      assign reg_o[s*REG_BITS +: REG_BITS]     = byte_q;
   end
endmodule

// File: rtl/dchain_spi_host.sv
module dchain_spi_host
   import dchain_pkg::*;
#(
   parameter int unsigned N_DEV     = 4,
   parameter int unsigned WORD_BITS = 24,
   parameter int unsigned DIV_W     = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start_i,
   input  logic                              rd_mode_i,
   input  logic [DIV_W-1:0]                  div_i,
   input  logic [N_DEV*WORD_BITS-1:0]        cmd_i,
   output logic                              busy_o,
   output logic                              done_o,
   output logic [N_DEV*WORD_BITS-1:0]        rdata_o,
   output logic [N_DEV*REG_BITS-1:0]         reg_o,
   output logic                              sclk_o,
   output logic                              cs_n_o,
   output logic                              mosi_o,
   input  logic                              miso_i
);
   localparam int unsigned TOT_BITS = N_DEV * WORD_BITS;
   localparam int unsigned LAST_PH  = 2 * TOT_BITS;
   localparam int unsigned PH_W     = $clog2(LAST_PH + 1) + 1;
   localparam int unsigned GAP_W    = $clog2(GAP_HALVES) + 1;

   if (N_DEV < 1 || N_DEV > 8) begin : g_bad_ndev
      $error("dchain_spi_host: N_DEV must be 1..8");
   end
   if (WORD_BITS != 24 && WORD_BITS != 32) begin : g_bad_word
      $error("dchain_spi_host: WORD_BITS must be 24 or 32");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("dchain_spi_host: DIV_W must be at least 1");
   end

   dc_state_e          state_q;
   logic [PH_W-1:0]    ph_q;
   logic [GAP_W-1:0]   gap_q;
   logic               sclk_q;
   logic               cs_n_q;
   logic               done_q;
   logic               mode_q;
   logic               tick;
   logic               accept;
   logic               last_ph;
   logic               drive;
   logic               sample;
   logic               commit;
   logic [TOT_BITS-1:0] rx_bits;

   assign accept  = (state_q == ST_IDLE) && start_i;
   assign last_ph = (ph_q == PH_W'(LAST_PH));
   assign drive   = (state_q == ST_RUN) && tick && !last_ph && !ph_q[0];
   assign sample  = (state_q == ST_RUN) && tick && !last_ph &&  ph_q[0];
   assign commit  = (state_q == ST_RUN) && tick &&  last_ph;

   dchain_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .div_i  (div_i),
      .run_i  (state_q != ST_IDLE),
      .tick_o (tick)
   );

   dchain_shifter #(.TOT_BITS(TOT_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .data_i   (cmd_i),
      .drive_i  (drive),
      .sample_i (sample),
      .clear_i  (commit),
      .miso_i   (miso_i),
      .mosi_o   (mosi_o),
      .rx_o     (rx_bits)
   );

   dchain_unpack #(.N_DEV(N_DEV), .WORD_BITS(WORD_BITS)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .rd_mode_i (mode_q),
      .rx_i      (rx_bits),
      .rdata_o   (rdata_o),
      .reg_o     (reg_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ph_q    <= '0;
         gap_q   <= '0;
         sclk_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         done_q  <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  cs_n_q  <= 1'b0;
                  ph_q    <= '0;
                  mode_q  <= rd_mode_i;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (last_ph) begin
                     cs_n_q  <= 1'b1;
                     done_q  <= 1'b1;
                     gap_q   <= '0;
                     state_q <= ST_GAP;
                  end else begin
                     sclk_q <= ~sclk_q;
                     ph_q   <= ph_q + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_q == GAP_W'(GAP_HALVES - 1)) begin
                     state_q <= ST_IDLE;
                  end else begin
                     gap_q <= gap_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign sclk_o = sclk_q;
   assign cs_n_o = cs_n_q;

   // R3: clock stays low outside the chip-select window
   a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

   // R3: serial output moves only on a rising clock edge
   a_r3_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!$rose(sclk_o) && $stable(cs_n_o)) |-> $stable(mosi_o));

   // R8: completion pulse coincides with chip select going high
   a_r8_done_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && !$past(cs_n_o)));

   // R9: controller stays busy across the inter-frame gap
   a_r9_gap_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> busy_o);

   // R7: result words change only on completion
   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rdata_o));

   // R7: register bytes change only on completion
   a_r7_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(reg_o));

   // R10: frame mode cannot be altered while busy
   a_r10_mode_latched: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mode_q));
endmodule

// File: tb/dchain_spi_host_tb.sv
module dchain_spi_host_tb_top;
   localparam int N_DEV     = 4;
   localparam int WORD_BITS = 24;
   localparam int DIV_W     = 8;
   localparam int TOT       = N_DEV * WORD_BITS;
   localparam int CLK_P     = 10;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start_i = 1'b0;
   logic                   rd_mode_i = 1'b0;
   logic [DIV_W-1:0]       div_i = '0;
   logic [TOT-1:0]         cmd_i = '0;
   logic                   busy_o, done_o, sclk_o, cs_n_o, mosi_o;
   logic [TOT-1:0]         rdata_o;
   logic [N_DEV*8-1:0]     reg_o;
   logic                   miso_i = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   dchain_spi_host #(.N_DEV(N_DEV), .WORD_BITS(WORD_BITS), .DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_mode_i(rd_mode_i),
      .div_i(div_i), .cmd_i(cmd_i), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o), .reg_o(reg_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
      .mosi_o(mosi_o), .miso_i(miso_i)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // behavioural chain of devices: one long shift path, far device at the top
   logic [TOT-1:0] chain = '0;
   logic [TOT-1:0] slave_src = '0;
   logic [TOT-1:0] rcv = '0;
   always @(negedge cs_n_o) chain = slave_src;
   always @(posedge sclk_o) if (!cs_n_o) miso_i = chain[TOT-1];
   always @(negedge sclk_o) if (!cs_n_o) chain = {chain[TOT-2:0], mosi_o};
   always @(posedge cs_n_o) rcv = chain;

   // per-cycle timing reference
   bit m_busy = 0;
   int m_k = 0;
   int m_h = 1;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0;
         m_k = 0;
      end else if (m_busy) begin
         m_k++;
         if (m_k == (2*TOT + 5) * m_h) m_busy = 0;
      end else if (start_i) begin
         m_busy = 1;
         m_k = 0;
         m_h = int'(div_i) + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit e_cs_n, e_done, e_sclk;
         int c;
         e_cs_n = !(m_busy && m_k < (2*TOT + 1) * m_h);
         e_done = m_busy && (m_k == (2*TOT + 1) * m_h);
         c = m_busy ? m_k / m_h : 0;
         if (c > 2*TOT) c = 2*TOT;
         e_sclk = c[0];
         chk(cs_n_o == e_cs_n, "R2 cs_n per cycle", cs_n_o, e_cs_n);
         chk(sclk_o == e_sclk, "R3 sclk per cycle", sclk_o, e_sclk);
         chk(done_o == e_done, "R8 done per cycle", done_o, e_done);
         chk(busy_o == m_busy, "R9 busy per cycle", busy_o, m_busy);
      end
   end

   logic [TOT-1:0]     exp_rdata = '0;
   logic [N_DEV*8-1:0] exp_reg = '0;

   function automatic logic [TOT-1:0] make_words(input logic [7:0] seed);
      logic [TOT-1:0] v;
      for (int d = 0; d < N_DEV; d++)
         v[d*WORD_BITS +: WORD_BITS] = {8'(seed + 8'(d*17)), 8'(~d), 8'(seed ^ 8'hA5 ^ 8'(d))};
      return v;
   endfunction

   function automatic logic [N_DEV*8-1:0] strip(input logic [TOT-1:0] v);
      logic [N_DEV*8-1:0] r;
      for (int d = 0; d < N_DEV; d++)
         r[d*8 +: 8] = v[d*WORD_BITS + WORD_BITS - 8 +: 8];
      return r;
   endfunction

   task automatic run_frame(input logic [TOT-1:0] cmd, input logic [TOT-1:0] resp,
                            input bit mode, input int div);
      slave_src = resp;
      @(negedge clk);
      cmd_i = cmd; rd_mode_i = mode; div_i = DIV_W'(div); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      // R10: disturb inputs and pulse start mid-frame
      cmd_i = ~cmd; rd_mode_i = ~mode; div_i = DIV_W'(div + 3); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      if (mode) exp_reg = strip(resp);
      else      exp_rdata = resp;
      chk(rcv == cmd, "R4 device words after frame", rcv, cmd);
      chk(rcv == cmd, "R10 latched command used", rcv, cmd);
      chk(rdata_o == exp_rdata, mode ? "R7 rdata kept in readback" : "R5 rdata slots",
          rdata_o, exp_rdata);
      chk(reg_o == exp_reg, mode ? "R6 register bytes stripped" : "R7 reg kept in data frame",
          reg_o, exp_reg);
      while (busy_o) @(negedge clk);
      cmd_i = '0; rd_mode_i = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL R2 watchdog act=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [TOT-1:0] rb;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(cs_n_o == 1'b1, "R1 cs_n in reset", cs_n_o, 1);
      chk(sclk_o == 1'b0, "R1 sclk in reset", sclk_o, 0);
      chk(mosi_o == 1'b0, "R1 mosi in reset", mosi_o, 0);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done in reset", {busy_o, done_o}, 0);
      chk(rdata_o == '0 && reg_o == '0, "R1 results in reset", rdata_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1 && mosi_o == 1'b0, "R1 idle after reset", {cs_n_o, mosi_o}, 2);

      // R2 R4 R5: data frames at several rates
      run_frame(make_words(8'h01), make_words(8'h5C), 1'b0, 0);
      run_frame(make_words(8'h3E), make_words(8'hC7), 1'b0, 2);
      // register read: command frame then readback frame (R6 R7)
      run_frame({N_DEV{8'h4A, 16'h0000}}, make_words(8'h90), 1'b0, 1);
      for (int d = 0; d < N_DEV; d++)
         rb[d*WORD_BITS +: WORD_BITS] = {8'(8'h21 + 8'(d*9)), 16'h0000};
      run_frame('0, rb, 1'b1, 1);
      // R6: non-zero filler bytes are still discarded
      for (int d = 0; d < N_DEV; d++)
         rb[d*WORD_BITS +: WORD_BITS] = {8'(8'hE3 ^ 8'(d)), 16'hBEEF};
      run_frame('0, rb, 1'b1, 0);
      // R7: a later data frame leaves register bytes intact
      run_frame(make_words(8'hF0), make_words(8'h0F), 1'b0, 3);
      repeat (10) @(negedge clk);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R10 no extra frame started", {cs_n_o, busy_o}, 2);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule